// File: doc/BRIEF.md
# Streaming Factory Program Controller

This controller runs a fast factory programming session on one erase block of a word-wide non-volatile array. The host opens the session with a two-word command sequence. After that it sends only data: each group of 512 writes fills an on-chip write buffer. The controller then programs that buffer into the array, with a verify after each word, and moves its own array pointer to the next 512-word boundary. The host sends no further commands, counts or addresses for the rest of the block.

The host follows progress by polling one status bit. While that bit is high, the buffer is being programmed and further writes are dropped. When it falls, the next 512 words may be streamed in. A session closes on its own after the last buffer of the block. The host may also close it early with an exit write, and it is aborted if a word keeps failing verify. A bounded retry count governs the verify step. A test input forces verify mismatches so that the retry path can be exercised.

Top module: `efp_stream_ctrl`

## Requirements
- R1: After reset the 8-bit status output reads 0x80. Bit 7 is ready (no session open), bit 5 is sequence error, bit 4 is program error, bit 3 is supply error and bit 0 is buffer busy. All other bits read 0.
- R2: A write of data 0x0080 in idle, followed by a write of 0x00D0, opens a session when the supply-good input is high and the address of the first write is a multiple of 512. The status then reads 0x00.
- R3: The confirm write is checked in a fixed order and any failure returns the controller to idle. First, data other than 0x00D0 gives status 0xB0. Otherwise, supply-good low gives 0x98. Otherwise, a start address that is not a multiple of 512 gives 0xB0.
- R4: During a session, the writes fill the buffer in arrival order and their addresses inside the block are disregarded. The edge that accepts the 512th word raises bit 0, and the change is visible in the next cycle.
- R5: Programming a buffer takes two cycles per word plus one extra cycle for each failed verify. Bit 0 falls on the edge that completes the last word.
- R6: Word i of the k-th buffer of a session lands at array address start + 512*k + i.
- R7: When the buffer that ends at the last word of the 1024-word block completes, the session closes and the status reads 0x80.
- R8: During filling, a write of all-ones data to an address outside the session's block closes the session with bit 7 set. Any words already in the partial buffer are discarded and never reach the array.
- R9: While the fault input is high, each program attempt stores the word with bit 0 inverted and fails verify. A word that fails verify 3 times in a row ends the session with status 0x90, and the array keeps the inverted word. Fewer consecutive failures are followed by a correct retry.
- R10: Writes that arrive while bit 0 is high have no effect on the status, the array or the session.
- R11: A write of 0x0050 in idle clears bits 5, 4 and 3. Other writes in idle have no effect.
- R12: A write of all-ones data to an address inside the block during filling is stored as an ordinary data word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe, one word per cycle |
| wr_addr | input | 11 | Host word address |
| wr_data | input | 16 | Host write data or command |
| vpp_ok | input | 1 | Programming supply at a usable level |
| verify_inject | input | 1 | Forces the current program attempt to fail verify |
| status | output | 8 | Registered status byte |
| rd_addr | input | 11 | Array read address |
| rd_data | output | 16 | Array read data, one cycle after rd_addr |

## Verification
A behavioural model in the bench predicts the status byte and is compared with the design on every cycle. The rejection sequences are sent one at a time, and one of them combines a low supply with a misaligned address. Together they show that each fault sets its own bits and that the checks are made in the stated order.

Three streaming sessions follow:
- A two-buffer session starting at block offset 0. It carries an all-ones word and scrambled host addresses, and the whole block is read back afterwards. Any word placed by host address instead of by arrival order shows up in the read-back.
- A session starting at offset 512 that is exited after ten words. The read-back of that range must still hold the older contents.
- A session held in constant verify failure until it aborts.

The busy interval is timed on a clean buffer and on a buffer with two injected failures. This separates a correct retry cost from a retry that is dropped or counted twice.

// File: rtl/efp_pkg.sv
package efp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_FILL,
    ST_PRD,
    ST_PWR
  } efp_state_e;

  localparam logic [7:0] CMD_OPEN    = 8'h80;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;
  localparam logic [7:0] CMD_CLEAR   = 8'h50;

  localparam int SB_READY = 7;
  localparam int SB_SEQ   = 5;
  localparam int SB_PGM   = 4;
  localparam int SB_SUPPLY = 3;
  localparam int SB_BUSY  = 0;

  localparam logic [7:0] STATUS_RESET = 8'h80;

endpackage

// File: rtl/efp_cmd_decode.sv
module efp_cmd_decode
  import efp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 11,
  parameter int BLK_W  = 10,
  parameter int BUF_W  = 9
) (
  input  logic [DATA_W-1:0]       wr_data,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [ADDR_W-BUF_W-1:0] base_hi,
  input  logic [BUF_W-1:0]        start_lo,
  output logic                    is_open,
  output logic                    is_confirm,
  output logic                    is_clear,
  output logic                    is_exit,
  output logic                    start_aligned,
  output logic                    last_buffer
);

  localparam int HI_W  = ADDR_W - BUF_W;
  localparam int BLK_HI = ADDR_W - BLK_W;

  logic [BLK_HI-1:0] cur_block;
  logic [BLK_HI-1:0] req_block;

  assign cur_block = base_hi[HI_W-1:HI_W-BLK_HI];
  assign req_block = wr_addr[ADDR_W-1:BLK_W];

  always_comb begin
    is_open       = (wr_data == DATA_W'(CMD_OPEN));
    is_confirm    = (wr_data == DATA_W'(CMD_CONFIRM));
    is_clear      = (wr_data == DATA_W'(CMD_CLEAR));
    is_exit       = (&wr_data) && (req_block != cur_block);
    start_aligned = (start_lo == '0);
    last_buffer   = &base_hi[HI_W-BLK_HI-1:0];
  end

endmodule

// File: rtl/efp_wbuf.sv
module efp_wbuf #(
  parameter int DATA_W = 16,
  parameter int BUF_W  = 9
) (
  input  logic              clk,
  input  logic              we,
  input  logic [BUF_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [BUF_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << BUF_W;

  logic [DATA_W-1:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/efp_array.sv
module efp_array #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              pgm_en,
  input  logic [ADDR_W-1:0] pgm_addr,
  input  logic [DATA_W-1:0] pgm_data,
  input  logic              inject,
  output logic              mismatch,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [DATA_W-1:0] FLIP = DATA_W'(1);

  logic [DATA_W-1:0] cells [0:DEPTH-1];
  logic [DATA_W-1:0] cell_word;

  // the word that actually lands in the cell, then compared against the request
  assign cell_word = inject ? (pgm_data ^ FLIP) : pgm_data;
  assign mismatch  = (cell_word != pgm_data);

  always_ff @(posedge clk) begin
    if (pgm_en) begin
      cells[pgm_addr] <= cell_word;
    end
    rd_data <= cells[rd_addr];
  end

endmodule

// File: rtl/efp_stream_ctrl.sv
module efp_stream_ctrl
  import efp_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 11,
  parameter int BLK_W     = 10,
  parameter int BUF_W     = 9,
  parameter int MAX_RETRY = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              vpp_ok,
  input  logic              verify_inject,
  output logic [7:0]        status,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  localparam int BUF_WORDS = 1 << BUF_W;
  localparam int HI_W      = ADDR_W - BUF_W;
  localparam int RTW       = $clog2(MAX_RETRY + 1);

  efp_state_e        state_q;
  logic [ADDR_W-1:0] start_q;
  logic [ADDR_W-1:0] base_q;
  logic [BUF_W-1:0]  cnt_q;
  logic [BUF_W-1:0]  idx_q;
  logic [RTW-1:0]    retry_q;
  logic [7:0]        sr_q;

  logic is_open, is_confirm, is_clear, is_exit, start_aligned, last_buffer;
  logic              buf_we;
  logic [DATA_W-1:0] buf_word;
  logic              pgm_en;
  logic [ADDR_W-1:0] pgm_addr;
  logic              mismatch;

  efp_cmd_decode #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BLK_W(BLK_W), .BUF_W(BUF_W)
  ) u_dec (
    .wr_data      (wr_data),
    .wr_addr      (wr_addr),
    .base_hi      (base_q[ADDR_W-1:BUF_W]),
    .start_lo     (start_q[BUF_W-1:0]),
    .is_open      (is_open),
    .is_confirm   (is_confirm),
    .is_clear     (is_clear),
    .is_exit      (is_exit),
    .start_aligned(start_aligned),
    .last_buffer  (last_buffer)
  );

  assign buf_we = (state_q == ST_FILL) && wr_en && !is_exit;

  efp_wbuf #(.DATA_W(DATA_W), .BUF_W(BUF_W)) u_wbuf (
    .clk  (clk),
    .we   (buf_we),
    .waddr(cnt_q),
    .wdata(wr_data),
    .raddr(idx_q),
    .rdata(buf_word)
  );

  assign pgm_en   = (state_q == ST_PWR);
  assign pgm_addr = {base_q[ADDR_W-1:BUF_W], idx_q};

  efp_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_array (
    .clk     (clk),
    .pgm_en  (pgm_en),
    .pgm_addr(pgm_addr),
    .pgm_data(buf_word),
    .inject  (verify_inject),
    .mismatch(mismatch),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      start_q <= '0;
      base_q  <= '0;
      cnt_q   <= '0;
      idx_q   <= '0;
      retry_q <= '0;
      sr_q    <= STATUS_RESET;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (wr_en && is_open) begin
            start_q        <= wr_addr;
            sr_q[SB_READY] <= 1'b0;
            state_q        <= ST_SETUP;
          end else if (wr_en && is_clear) begin
            sr_q[SB_SEQ]    <= 1'b0;
            sr_q[SB_PGM]    <= 1'b0;
            sr_q[SB_SUPPLY] <= 1'b0;
          end
        end
        ST_SETUP: begin
          if (wr_en) begin
            if (!is_confirm || (vpp_ok && !start_aligned)) begin
              sr_q[SB_READY] <= 1'b1;
              sr_q[SB_SEQ]   <= 1'b1;
              sr_q[SB_PGM]   <= 1'b1;
              state_q        <= ST_IDLE;
            end else if (!vpp_ok) begin
              sr_q[SB_READY]  <= 1'b1;
              sr_q[SB_PGM]    <= 1'b1;
              sr_q[SB_SUPPLY] <= 1'b1;
              state_q         <= ST_IDLE;
            end else begin
              base_q  <= start_q;
              cnt_q   <= '0;
              state_q <= ST_FILL;
            end
          end
        end
        ST_FILL: begin
          if (wr_en) begin
            if (is_exit) begin
              sr_q[SB_READY] <= 1'b1;
              state_q        <= ST_IDLE;
            end else if (&cnt_q) begin
              cnt_q         <= '0;
              idx_q         <= '0;
              sr_q[SB_BUSY] <= 1'b1;
              state_q       <= ST_PRD;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        ST_PRD: begin
          retry_q <= '0;
          state_q <= ST_PWR;
        end
        ST_PWR: begin
          if (mismatch) begin
            if (retry_q == RTW'(MAX_RETRY - 1)) begin
              sr_q[SB_READY] <= 1'b1;
              sr_q[SB_PGM]   <= 1'b1;
              sr_q[SB_BUSY]  <= 1'b0;
              state_q        <= ST_IDLE;
            end else begin
              retry_q <= retry_q + 1'b1;
            end
          end else if (&idx_q) begin
            sr_q[SB_BUSY] <= 1'b0;
            if (last_buffer) begin
              sr_q[SB_READY] <= 1'b1;
              state_q        <= ST_IDLE;
            end else begin
              base_q  <= base_q + ADDR_W'(BUF_WORDS);
              cnt_q   <= '0;
              state_q <= ST_FILL;
            end
          end else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= ST_PRD;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign status = sr_q;

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    sr_q[SB_BUSY] |-> !sr_q[SB_READY]); // R5

  AST_BUSY_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
    $rose(sr_q[SB_BUSY]) |-> $past(wr_en)); // R4

  AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FILL || state_q == ST_PRD || state_q == ST_PWR)
      |-> (base_q[BUF_W-1:0] == '0)); // R6

  AST_BASE_STEP: assert property (@(posedge clk) disable iff (rst)
    ($past(state_q) == ST_PWR && state_q == ST_FILL)
      |-> (base_q == $past(base_q) + ADDR_W'(BUF_WORDS))); // R7

  AST_RETRY_BOUND: assert property (@(posedge clk) disable iff (rst)
    retry_q < RTW'(MAX_RETRY)); // R9

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_PRD) |=> (state_q == ST_PWR && sr_q[SB_BUSY])); // R10

endmodule

// File: tb/efp_stream_ctrl_test.sv
module efp_stream_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 11;
  localparam int DW = 16;
  localparam int BLK = 1024;
  localparam int BUFN = 512;
  localparam int WATCHDOG = 60000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic vpp_ok = 1'b1;
  logic verify_inject = 1'b0;
  logic [7:0] status;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit started = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  efp_stream_ctrl uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .vpp_ok(vpp_ok), .verify_inject(verify_inject), .status(status),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // behavioural reference model
  int m_st;          // 0 idle, 1 confirm wait, 2 filling, 3 programming
  logic [7:0] m_status;
  int m_start, m_base, m_idx, m_retry;
  bit m_phase;
  logic [DW-1:0] m_buf[$];
  logic [DW-1:0] m_arr [0:2047];

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_st = 0; m_status = 8'h80; m_buf.delete();
    end else begin
      case (m_st)
        0: if (wr_en) begin
          if (wr_data == 16'h0080) begin m_st = 1; m_start = int'(wr_addr); m_status[7] = 1'b0; end
          else if (wr_data == 16'h0050) m_status = m_status & 8'hC7;
        end
        1: if (wr_en) begin
          if (wr_data != 16'h00D0) begin m_status = m_status | 8'hB0; m_st = 0; end
          else if (!vpp_ok) begin m_status = m_status | 8'h98; m_st = 0; end
          else if (m_start % BUFN != 0) begin m_status = m_status | 8'hB0; m_st = 0; end
          else begin m_st = 2; m_base = m_start; m_buf.delete(); end
        end
        2: if (wr_en) begin
          if (wr_data == 16'hFFFF && (int'(wr_addr) / BLK) != (m_base / BLK)) begin
            m_st = 0; m_status[7] = 1'b1;
          end else begin
            m_buf.push_back(wr_data);
            if (m_buf.size() == BUFN) begin
              m_st = 3; m_status[0] = 1'b1; m_idx = 0; m_phase = 0; m_retry = 0;
            end
          end
        end
        3: begin
          if (!m_phase) begin
            m_phase = 1;
          end else if (verify_inject) begin
            m_arr[m_base + m_idx] = m_buf[m_idx] ^ 16'h0001;
            if (m_retry == 2) begin m_status = m_status | 8'h90; m_status[0] = 1'b0; m_st = 0; end
            else m_retry++;
          end else begin
            m_arr[m_base + m_idx] = m_buf[m_idx];
            if (m_idx == BUFN - 1) begin
              m_status[0] = 1'b0;
              if (m_base % BLK == BLK - BUFN) begin m_status[7] = 1'b1; m_st = 0; end
              else begin m_base += BUFN; m_buf.delete(); m_st = 2; end
            end else begin
              m_idx++; m_phase = 0; m_retry = 0;
            end
          end
        end
        default: m_st = 0;
      endcase
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // per-cycle comparison of status against the model
  always @(negedge clk) begin
    if (started && !rst) chk(cur_req, {24'd0, status}, {24'd0, m_status});
  end

  always @(posedge clk) begin
    if (cyc > WATCHDOG) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wr(input int a, input logic [DW-1:0] d);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [DW-1:0] d);
    rd_addr = AW'(a);
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic wait_idle_busy(output int span, input int c0);
    int guard = 0;
    while (status[0] && guard < 4000) begin
      @(negedge clk); guard++;
    end
    span = cyc - c0;
  endtask

  function automatic logic [DW-1:0] pat0(input int i);
    return (i == 100) ? 16'hFFFF : 16'(16'h1000 + i * 7);
  endfunction

  initial begin
    logic [DW-1:0] v;
    int c0, span;
    repeat (3) @(negedge clk);
    started = 1;
    rst = 1'b0;
    chk("R1", {24'd0, status}, 32'h80);

    cur_req = "R11";
    wr(7, 16'h1234);
    chk("R11", {24'd0, status}, 32'h80);

    cur_req = "R3";
    wr(0, 16'h0080); wr(0, 16'h0040);
    chk("R3", {24'd0, status}, 32'hB0);
    wr(0, 16'h0050);
    chk("R11", {24'd0, status}, 32'h80);
    wr(5, 16'h0080); wr(5, 16'h00D0);
    chk("R3", {24'd0, status}, 32'hB0);
    wr(0, 16'h0050);
    vpp_ok = 1'b0;
    wr(5, 16'h0080); wr(5, 16'h00D0);
    chk("R3", {24'd0, status}, 32'h98);
    vpp_ok = 1'b1;
    wr(0, 16'h0050);
    chk("R11", {24'd0, status}, 32'h80);

    // two-buffer session over block 0
    cur_req = "R2";
    wr(0, 16'h0080); wr(0, 16'h00D0);
    chk("R2", {24'd0, status}, 32'h00);
    cur_req = "R4";
    for (int i = 0; i < BUFN; i++) wr(1023 - i, pat0(i));
    chk("R4", {24'd0, status}, 32'h01);
    c0 = cyc;
    cur_req = "R5";
    wait_idle_busy(span, c0);
    chk("R5", span, 1024);
    chk("R5", {24'd0, status}, 32'h00);

    cur_req = "R4";
    for (int i = 0; i < BUFN; i++) wr(i * 2 % BLK, 16'h8000 ^ 16'(i));
    c0 = cyc;
    cur_req = "R10";
    wr(3, 16'hDEAD); wr(0, 16'h0080); wr(1500, 16'hFFFF);
    chk("R10", {24'd0, status}, 32'h01);
    cur_req = "R9";
    verify_inject = 1'b1;
    repeat (2) @(negedge clk);
    verify_inject = 1'b0;
    wait_idle_busy(span, c0);
    chk("R5", span, 1026);
    cur_req = "R7";
    chk("R7", {24'd0, status}, 32'h80);

    cur_req = "R6";
    for (int i = 0; i < BLK; i++) begin
      rd(i, v);
      chk((i == 100) ? "R12" : "R6", {16'd0, v},
          {16'd0, (i < BUFN) ? pat0(i) : (16'h8000 ^ 16'(i - BUFN))});
    end

    // exit from a partial buffer at offset 512
    cur_req = "R8";
    wr(512, 16'h0080); wr(512, 16'h00D0);
    chk("R2", {24'd0, status}, 32'h00);
    for (int i = 0; i < 10; i++) wr(512 + i, 16'h5555);
    wr(BLK + 3, 16'hFFFF);
    chk("R8", {24'd0, status}, 32'h80);
    repeat (4) @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      rd(512 + i, v);
      chk("R8", {16'd0, v}, {16'd0, 16'h8000 ^ 16'(i)});
    end

    // persistent verify failure in block 1
    cur_req = "R9";
    wr(BLK, 16'h0080); wr(BLK, 16'h00D0);
    for (int i = 0; i < BUFN; i++) wr(BLK + i, 16'(16'h2000 + i));
    c0 = cyc;
    verify_inject = 1'b1;
    wait_idle_busy(span, c0);
    verify_inject = 1'b0;
    chk("R9", {24'd0, status}, 32'h90);
    chk("R9", span, 4);
    rd(BLK, v);
    chk("R9", {16'd0, v}, 32'h2001);
    cur_req = "R11";
    wr(0, 16'h0050);
    chk("R11", {24'd0, status}, 32'h80);

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule